// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers and the status words of a 32-bit RISC core with several operating modes. Software always sees sixteen registers, r0 to r15. Some of them exist in more than one physical copy, and the copy used is chosen by the mode field in the low five bits of the current status word. Index 15 acts as the program counter and has its own increment path. By convention, r13 serves as the stack pointer and r14 holds the return address.

Each of the four ordinary exception modes has a private r13 and r14. The fast-interrupt mode also has private copies of r8 to r12, so its handler can use them without saving anything. User mode and system mode use the same registers. The block also holds the current status word and one saved status word for each of the five exception modes.

The block has two combinational read ports and one clocked write port, each addressed by architectural index. A mapper turns each index into a physical slot using the mode currently stored. Instruction decode, arithmetic and exception sequencing are handled elsewhere.

Top module: `banked_regfile`

## Requirements
- R1: After reset, the status word reads 0x000000D3 (supervisor mode with both interrupt disables set), every register reads zero, and the saved status word reads zero.
- R2: Indices 0 to 7 and index 15 address the same physical register in every mode.
- R3: In fast-interrupt mode (mode field 10001), indices 8 to 14 use private copies. Writes there are not seen in user mode, and writes in user mode are not seen there.
- R4: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have a private r13 and r14. In these modes, indices 8 to 12 use the user copies.
- R5: System mode (11111) uses every user-mode register.
- R6: A mode field matching none of the seven encodings selects the user registers.
- R7: Both read ports are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R8: With pc_inc high, index 15 advances by 4 at each edge. A write to index 15 in the same cycle takes priority over the increment.
- R9: A status write keeps only bits 31:28 (flags N Z C V), 7:6 (interrupt disables I F), 5 (T state) and 4:0 (mode). All other bits read zero. The new mode steers accesses from the next cycle on.
- R10: Each exception mode has its own saved status word, masked like the status word and chosen by the current mode. In user or system mode, a saved-status read returns zero and a saved-status write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Write architectural index |
| wr_data | input | 32 | Write data |
| pc_inc | input | 1 | Advance index 15 by one instruction step |
| psr_wr_en | input | 1 | Current status write enable |
| psr_wr_data | input | 32 | Current status write data |
| psr_q | output | 32 | Current status word |
| saved_wr_en | input | 1 | Saved status write enable for the current mode |
| saved_wr_data | input | 32 | Saved status write data |
| saved_rd_data | output | 32 | Saved status word of the current mode |

## Verification
Registers are given different values in user, fast-interrupt, interrupt, supervisor and system modes, then read back after each mode switch. This separates shared slots from banked ones, and separates the fast-interrupt bank from the two-register banks. An undefined mode code is used to show that it falls back to the user registers. Reads of a register in the cycle it is written tell registered data apart from bypassed data. Runs of increments, and an increment paired with a write to index 15, show which of the two takes priority. Writes of all-ones status words, and saved-status traffic in user and system modes, exercise the masking and the ignore rule.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int XLEN     = 32;
  localparam int ARCH_W   = 4;
  localparam int NARCH    = 1 << ARCH_W;
  localparam int MODE_W   = 5;
  localparam int FIQ_LO   = 8;
  localparam int SP_IDX   = 13;
  localparam int LR_IDX   = 14;
  localparam int PC_IDX   = 15;
  localparam int FIQ_CNT  = LR_IDX - FIQ_LO + 1;
  localparam int EXC_CNT  = 4;
  localparam int FIQ_BASE = NARCH;
  localparam int EXC_BASE = FIQ_BASE + FIQ_CNT;
  localparam int NPHYS    = EXC_BASE + 2 * EXC_CNT;
  localparam int PHYS_W   = $clog2(NPHYS);
  localparam int NSAVED   = 5;
  localparam int SLOT_W   = 3;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam logic [XLEN-1:0] PSR_MASK  = 32'hF000_00FF;
  localparam logic [XLEN-1:0] PSR_RESET = 32'h0000_00D3;
  localparam logic [SLOT_W-1:0] NO_SLOT = 3'd7;

  function automatic logic [SLOT_W-1:0] saved_slot(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: saved_slot = 3'd0;
      MODE_IRQ: saved_slot = 3'd1;
      MODE_SVC: saved_slot = 3'd2;
      MODE_ABT: saved_slot = 3'd3;
      MODE_UND: saved_slot = 3'd4;
      default:  saved_slot = NO_SLOT;
    endcase
  endfunction
endpackage

// File: rtl/rfb_bank_map.sv
module rfb_bank_map
  import rfb_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ARCH_W-1:0] arch_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic [PHYS_W-1:0] arch_ext;
  logic [1:0]        exc_k;
  logic              is_pair;

  assign arch_ext = PHYS_W'(arch_i);
  assign is_pair  = (arch_i == ARCH_W'(SP_IDX)) || (arch_i == ARCH_W'(LR_IDX));

  always_comb begin
    case (mode_i)
      MODE_SVC: exc_k = 2'd1;
      MODE_ABT: exc_k = 2'd2;
      MODE_UND: exc_k = 2'd3;
      default:  exc_k = 2'd0;
    endcase
  end

  always_comb begin
    phys_o = arch_ext;
    case (mode_i)
      MODE_FIQ: begin
        if (arch_i >= ARCH_W'(FIQ_LO) && arch_i <= ARCH_W'(LR_IDX))
          phys_o = arch_ext + PHYS_W'(FIQ_BASE - FIQ_LO);
      end
      MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: begin
        if (is_pair)
          phys_o = PHYS_W'(EXC_BASE) + PHYS_W'({exc_k, arch_i == ARCH_W'(LR_IDX)});
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rfb_gpr_array.sv
module rfb_gpr_array
  import rfb_pkg::*;
#(
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHYS_W-1:0] rd_a_phys,
  input  logic [PHYS_W-1:0] rd_b_phys,
  output logic [XLEN-1:0]   rd_a_data,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              pc_inc
);
  logic [XLEN-1:0] regs_q [NPHYS];
  logic [XLEN-1:0] regs_d [NPHYS];
  logic            pc_written;

  assign pc_written = wr_en && (wr_phys == PHYS_W'(PC_IDX));

  always_comb begin
    for (int i = 0; i < NPHYS; i++) regs_d[i] = regs_q[i];
    if (pc_inc) regs_d[PC_IDX] = regs_q[PC_IDX] + XLEN'(PC_STEP);
    if (wr_en)  regs_d[wr_phys] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPHYS; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign rd_a_data = regs_q[rd_a_phys];
  assign rd_b_data = regs_q[rd_b_phys];

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !pc_written) |=> regs_q[PC_IDX] == $past(regs_q[PC_IDX]) + XLEN'(PC_STEP)); // R8
  AST_PC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_written |=> regs_q[PC_IDX] == $past(wr_data)); // R8
  AST_WRITE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_phys < PHYS_W'(NPHYS)); // R3
endmodule

// File: rtl/rfb_psr_store.sv
module rfb_psr_store
  import rfb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            psr_wr_en,
  input  logic [XLEN-1:0] psr_wr_data,
  output logic [XLEN-1:0] psr_q,
  input  logic            saved_wr_en,
  input  logic [XLEN-1:0] saved_wr_data,
  output logic [XLEN-1:0] saved_rd_data
);
  logic [XLEN-1:0]              cpsr_q, cpsr_d;
  logic [NSAVED-1:0][XLEN-1:0]  spsr_q, spsr_d;
  logic [SLOT_W-1:0]            slot;
  logic                         slot_ok;

  assign slot    = saved_slot(cpsr_q[MODE_W-1:0]);
  assign slot_ok = slot < SLOT_W'(NSAVED);

  always_comb begin
    cpsr_d = cpsr_q;
    if (psr_wr_en) cpsr_d = psr_wr_data & PSR_MASK;
  end

  always_comb begin
    spsr_d = spsr_q;
    if (saved_wr_en && slot_ok) spsr_d[slot] = saved_wr_data & PSR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsr_q <= PSR_RESET;
      spsr_q <= '0;
    end else begin
      cpsr_q <= cpsr_d;
      spsr_q <= spsr_d;
    end
  end

  assign psr_q         = cpsr_q;
  assign saved_rd_data = slot_ok ? spsr_q[slot] : '0;

  AST_PSR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    psr_wr_en |=> psr_q == ($past(psr_wr_data) & PSR_MASK)); // R9
  AST_SAVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_q[MODE_W-1:0] == MODE_USR || psr_q[MODE_W-1:0] == MODE_SYS) |-> saved_rd_data == '0); // R10
  AST_SAVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (saved_wr_en && !slot_ok) |=> $stable(spsr_q)); // R10
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rfb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARCH_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [ARCH_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              pc_inc,
  input  logic              psr_wr_en,
  input  logic [XLEN-1:0]   psr_wr_data,
  output logic [XLEN-1:0]   psr_q,
  input  logic              saved_wr_en,
  input  logic [XLEN-1:0]   saved_wr_data,
  output logic [XLEN-1:0]   saved_rd_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [MODE_W-1:0] mode;
  logic [PHYS_W-1:0] phys_a, phys_b, phys_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode = psr_q[MODE_W-1:0];

  rfb_bank_map u_map_a (.mode_i(mode), .arch_i(rd_a_idx), .phys_o(phys_a));
  rfb_bank_map u_map_b (.mode_i(mode), .arch_i(rd_b_idx), .phys_o(phys_b));
  rfb_bank_map u_map_w (.mode_i(mode), .arch_i(wr_idx),   .phys_o(phys_w));

  rfb_gpr_array #(.PC_STEP(4)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_a_phys (phys_a),
    .rd_b_phys (phys_b),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_phys   (phys_w),
    .wr_data   (wr_data),
    .pc_inc    (pc_inc)
  );

  rfb_psr_store u_psr (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .psr_wr_en     (psr_wr_en),
    .psr_wr_data   (psr_wr_data),
    .psr_q         (psr_q),
    .saved_wr_en   (saved_wr_en),
    .saved_wr_data (saved_wr_data),
    .saved_rd_data (saved_rd_data)
  );

  AST_SHARED_SLOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_a_idx < ARCH_W'(FIQ_LO) || rd_a_idx == ARCH_W'(PC_IDX)) |-> phys_a == PHYS_W'(rd_a_idx)); // R2
  AST_FIQ_PRIVATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_FIQ && rd_a_idx >= ARCH_W'(FIQ_LO) && rd_a_idx != ARCH_W'(PC_IDX))
      |-> phys_a >= PHYS_W'(FIQ_BASE)); // R3
  AST_USER_FALLBACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (saved_slot(mode) == NO_SLOT) |-> phys_b == PHYS_W'(rd_b_idx)); // R6
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, pc_inc, psr_wr_en, saved_wr_en;
  logic [31:0] psr_wr_data, psr_q, saved_wr_data, saved_rd_data;

  int checks = 0;
  int fails  = 0;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011;
  localparam logic [4:0] ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111, BAD = 5'b10100;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_inc(pc_inc),
    .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data), .psr_q(psr_q),
    .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_rd_data(saved_rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [3:0] idx, input logic [31:0] exp);
    rd_a_idx = idx;
    rd_b_idx = idx;
    #1;
    check(req, rd_a_data, exp);
    check(req, rd_b_data, exp);
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk);
    psr_wr_en = 1'b1;
    psr_wr_data = {27'd0, m};
    @(negedge clk);
    psr_wr_en = 1'b0;
  endtask

  task automatic write_reg(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_saved(input logic [31:0] d);
    @(negedge clk);
    saved_wr_en = 1'b1; saved_wr_data = d;
    @(negedge clk);
    saved_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", psr_q, 32'h0000_00D3);
    check("R1", saved_rd_data, 32'h0);
    for (int i = 0; i < 16; i++) check_reg("R1", 4'(i), 32'h0);
  endtask

  task automatic t_pc;
    @(negedge clk);
    pc_inc = 1'b1;
    repeat (3) @(negedge clk);
    pc_inc = 1'b0;
    check_reg("R8", 4'd15, 32'd12);
    @(negedge clk);
    pc_inc = 1'b1; wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_1000;
    @(negedge clk);
    pc_inc = 1'b0; wr_en = 1'b0;
    check_reg("R8", 4'd15, 32'h0000_1000);
  endtask

  task automatic t_shared;
    set_mode(USR);
    write_reg(4'd0, 32'h0000_00AA);
    write_reg(4'd7, 32'h0000_0077);
    set_mode(FIQ);
    check_reg("R2", 4'd0, 32'h0000_00AA);
    set_mode(UND);
    check_reg("R2", 4'd7, 32'h0000_0077);
    check_reg("R2", 4'd15, 32'h0000_1000);
    set_mode(ABT);
    check_reg("R2", 4'd0, 32'h0000_00AA);
  endtask

  task automatic t_fiq;
    set_mode(USR);
    for (int i = 8; i <= 14; i++) write_reg(4'(i), 32'h100 + 32'(i));
    set_mode(FIQ);
    check_reg("R3", 4'd8, 32'h0);
    check_reg("R3", 4'd12, 32'h0);
    check_reg("R3", 4'd14, 32'h0);
    for (int i = 8; i <= 14; i++) write_reg(4'(i), 32'h200 + 32'(i));
    check_reg("R3", 4'd10, 32'h20A);
    set_mode(USR);
    check_reg("R3", 4'd8, 32'h108);
    check_reg("R3", 4'd13, 32'h10D);
  endtask

  task automatic t_exc;
    set_mode(IRQ);
    check_reg("R4", 4'd8, 32'h108);
    check_reg("R4", 4'd12, 32'h10C);
    check_reg("R4", 4'd13, 32'h0);
    write_reg(4'd13, 32'h313);
    write_reg(4'd14, 32'h314);
    set_mode(SVC);
    check_reg("R4", 4'd13, 32'h0);
    write_reg(4'd13, 32'h413);
    set_mode(IRQ);
    check_reg("R4", 4'd13, 32'h313);
    check_reg("R4", 4'd14, 32'h314);
    set_mode(SVC);
    check_reg("R4", 4'd13, 32'h413);
    set_mode(USR);
    check_reg("R4", 4'd13, 32'h10D);
  endtask

  task automatic t_sys;
    set_mode(SYS);
    check_reg("R5", 4'd13, 32'h10D);
    check_reg("R5", 4'd9, 32'h109);
    write_reg(4'd13, 32'h55);
    set_mode(USR);
    check_reg("R5", 4'd13, 32'h55);
  endtask

  task automatic t_unknown;
    set_mode(BAD);
    check_reg("R6", 4'd13, 32'h55);
    check_reg("R6", 4'd8, 32'h108);
  endtask

  task automatic t_no_bypass;
    set_mode(USR);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h3333;
    rd_a_idx = 4'd3; rd_b_idx = 4'd3;
    #1;
    check("R7", rd_a_data, 32'h0);
    check("R7", rd_b_data, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R7", rd_a_data, 32'h3333);
  endtask

  task automatic t_psr;
    @(negedge clk);
    psr_wr_en = 1'b1; psr_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    psr_wr_en = 1'b0;
    check("R9", psr_q, 32'hF000_00FF);
    check_reg("R9", 4'd13, 32'h55);
    @(negedge clk);
    psr_wr_en = 1'b1; psr_wr_data = 32'h6A00_0F13;
    @(negedge clk);
    psr_wr_en = 1'b0;
    check("R9", psr_q, 32'h6000_0013);
    check_reg("R9", 4'd13, 32'h413);
  endtask

  task automatic t_saved;
    set_mode(FIQ);
    write_saved(32'hA000_00D1);
    check("R10", saved_rd_data, 32'hA000_00D1);
    set_mode(IRQ);
    check("R10", saved_rd_data, 32'h0);
    write_saved(32'h1234_5692);
    check("R10", saved_rd_data, 32'h1000_0092);
    set_mode(FIQ);
    check("R10", saved_rd_data, 32'hA000_00D1);
    set_mode(USR);
    check("R10", saved_rd_data, 32'h0);
    write_saved(32'hFFFF_FFFF);
    check("R10", saved_rd_data, 32'h0);
    set_mode(SYS);
    write_saved(32'h5000_0010);
    check("R10", saved_rd_data, 32'h0);
    set_mode(IRQ);
    check("R10", saved_rd_data, 32'h1000_0092);
    set_mode(SVC);
    check("R10", saved_rd_data, 32'h0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0;
    wr_en = 1'b0; pc_inc = 1'b0; psr_wr_en = 1'b0; psr_wr_data = '0;
    saved_wr_en = 1'b0; saved_wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pc();
    t_shared();
    t_fiq();
    t_exc();
    t_sys();
    t_unknown();
    t_no_bypass();
    t_psr();
    t_saved();
    summary();
  end
endmodule